// File: doc/BRIEF.md
# Timestamp Latency Compensation Unit

This unit adjusts timestamps taken inside a MAC datapath. A timestamp is captured some number of pipeline stages away from the physical interface bus. The unit moves it to the time at which the data crosses that bus. The raw time is held as 48 bits of nanoseconds plus 16 bits of fractional nanoseconds. The unit adds the clock period multiplied by the stage count, then adds a static offset made of nanoseconds and fractional nanoseconds. The transmit and receive paths each have their own period and offset settings, and both paths can compute in the same cycle.

Each path keeps two period settings. One is for the high line rate and one is for the lower rates. A line-rate mode input chooses which period is used. In two of the low-rate modes the programmed value is not used, and a fixed period is applied instead. Settings are loaded through a simple write port. The port is accepted only while the datapath enable is low, so the values cannot change while the datapath is running.

Top module: `ts_lat_comp`

## Requirements
- R1: After reset, each direction uses a high-rate period of 0x33333 (3.2 ns) and a low-rate period of 0x80000 (8 ns), and both static offsets are zero. Period values carry whole nanoseconds in bits 19:16 and fractional nanoseconds (units of 2^-16 ns) in bits 15:0. Both valid outputs are low and both timestamp outputs are zero until the first valid input.
- R2: The output time equals the raw time plus the period multiplied by the stage count, plus {offset ns, offset fns}. All three terms are 64-bit fixed-point values with 16 fractional bits. A carry out of the fractional field enters the nanosecond field.
- R3: The valid output equals the valid input delayed by one clock, and the result appears in that same cycle. While the valid input is low, the timestamp outputs keep their previous values.
- R4: Mode 0 (rate_i = 0, high rate) uses the direction's programmed high-rate period.
- R5: Mode 1 (low rate) uses the direction's programmed low-rate period.
- R6: Mode 2 (1G) uses a fixed period of 16 ns (0x100000) and ignores the programmed low-rate period.
- R7: Mode 3 (2.5G) uses a fixed period of 6.4 ns (0x66666) and ignores the programmed low-rate period.
- R8: The register map uses cfg_addr_i[2] to select the direction (0 = TX, 1 = RX). cfg_addr_i[1:0] selects the register: 0 high-rate period, 1 low-rate period, 2 offset ns, 3 offset fns. Write-data bits 31:20 of a period write are ignored, and so are bits 31:16 of an offset write.
- R9: A write made while en_i is high changes no setting. A write made while en_i is low takes effect for the next valid input.
- R10: A write to one direction leaves the other direction's settings unchanged.
- R11: The sum wraps modulo 2^64. Bits beyond the 48-bit nanosecond field are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Datapath enable; settings are locked while high |
| rate_i | input | 2 | Line-rate mode: 0 high, 1 low, 2 1G, 3 2.5G |
| cfg_we_i | input | 1 | Settings write strobe |
| cfg_addr_i | input | 3 | Settings address: direction bit and register index |
| cfg_wdata_i | input | 32 | Settings write data |
| tx_vld_i | input | 1 | TX raw timestamp valid |
| tx_ns_i | input | 48 | TX raw timestamp, nanoseconds |
| tx_fns_i | input | 16 | TX raw timestamp, fractional nanoseconds |
| tx_stg_i | input | 4 | TX pipeline stage count |
| rx_vld_i | input | 1 | RX raw timestamp valid |
| rx_ns_i | input | 48 | RX raw timestamp, nanoseconds |
| rx_fns_i | input | 16 | RX raw timestamp, fractional nanoseconds |
| rx_stg_i | input | 4 | RX pipeline stage count |
| tx_vld_o | output | 1 | TX compensated timestamp valid |
| tx_ns_o | output | 48 | TX compensated timestamp, nanoseconds |
| tx_fns_o | output | 16 | TX compensated timestamp, fractional nanoseconds |
| rx_vld_o | output | 1 | RX compensated timestamp valid |
| rx_ns_o | output | 48 | RX compensated timestamp, nanoseconds |
| rx_fns_o | output | 16 | RX compensated timestamp, fractional nanoseconds |

## Verification
The hardest case to reach from the ports is a forced-period mode running against a programmed low-rate period that differs from every fixed value. With default settings, ignoring the register and honouring it can produce the same output. The stimulus therefore loads distinct periods and offsets into both directions first. It then sweeps every mode against all sixteen stage counts, using raw fractional values close to 0xFFFF so that the fractional carry is exercised. It also tries writes while enabled and writes with the reserved bits set, and confirms the result only through later compensated outputs.

// File: rtl/ts_lat_pkg.sv
package ts_lat_pkg;

  typedef enum logic [1:0] {
    RATE_HIGH = 2'd0,
    RATE_LOW  = 2'd1,
    RATE_1G   = 2'd2,
    RATE_2G5  = 2'd3
  } rate_e;

  typedef enum logic [1:0] {
    REG_PER_HI  = 2'd0,
    REG_PER_LO  = 2'd1,
    REG_ADJ_NS  = 2'd2,
    REG_ADJ_FNS = 2'd3
  } reg_idx_e;

  localparam int unsigned DIR_N = 2;

  // period in tenths of ns -> fixed point with fns_w fractional bits
  function automatic int unsigned fix_period(input int unsigned tenths_ns, input int unsigned fns_w);
    return (tenths_ns << fns_w) / 10;
  endfunction

endpackage

// File: rtl/ts_lat_cfg.sv
module ts_lat_cfg
  import ts_lat_pkg::*;
#(
  parameter int unsigned DIR_ID   = 0,
  parameter int unsigned FNS_W    = 16,
  parameter int unsigned PER_NS_W = 4,
  parameter int unsigned ADJ_NS_W = 16,
  parameter int unsigned CFG_DW   = 32,
  localparam int unsigned PER_FLD_W = PER_NS_W + FNS_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 we_i,
  input  logic [2:0]           addr_i,
  input  logic [CFG_DW-1:0]    wdata_i,
  output logic [PER_FLD_W-1:0] per_hi_o,
  output logic [PER_FLD_W-1:0] per_lo_o,
  output logic [ADJ_NS_W-1:0]  adj_ns_o,
  output logic [FNS_W-1:0]     adj_fns_o
);

  localparam logic [PER_FLD_W-1:0] HI_RST = PER_FLD_W'(fix_period(32, FNS_W));
  localparam logic [PER_FLD_W-1:0] LO_RST = PER_FLD_W'(fix_period(80, FNS_W));

  logic     sel_dir;
  logic     wr_ok;
  reg_idx_e idx;

  assign sel_dir = (addr_i[2] == 1'(DIR_ID));
  assign wr_ok   = we_i && !en_i && sel_dir;
  assign idx     = reg_idx_e'(addr_i[1:0]);

  logic [PER_FLD_W-1:0] hi_q, lo_q;
  logic [ADJ_NS_W-1:0]  ans_q;
  logic [FNS_W-1:0]     afns_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= HI_RST;
      lo_q   <= LO_RST;
      ans_q  <= '0;
      afns_q <= '0;
    end else if (wr_ok) begin
      unique case (idx)
        REG_PER_HI:  hi_q   <= wdata_i[PER_FLD_W-1:0];
        REG_PER_LO:  lo_q   <= wdata_i[PER_FLD_W-1:0];
        REG_ADJ_NS:  ans_q  <= wdata_i[ADJ_NS_W-1:0];
        REG_ADJ_FNS: afns_q <= wdata_i[FNS_W-1:0];
        default: ;
      endcase
    end
  end

  logic rsv_unused;
  assign rsv_unused = ^wdata_i;

  assign per_hi_o  = hi_q;
  assign per_lo_o  = lo_q;
  assign adj_ns_o  = ans_q;
  assign adj_fns_o = afns_q;

  p_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ($stable(hi_q) && $stable(lo_q) && $stable(ans_q) && $stable(afns_q)));

  p_other_dir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sel_dir) |=> ($stable(hi_q) && $stable(lo_q) && $stable(ans_q) && $stable(afns_q)));

endmodule

// File: rtl/ts_lat_per_sel.sv
module ts_lat_per_sel
  import ts_lat_pkg::*;
#(
  parameter int unsigned FNS_W    = 16,
  parameter int unsigned PER_NS_W = 4,
  localparam int unsigned PER_FLD_W = PER_NS_W + FNS_W,
  localparam int unsigned PER_W     = PER_FLD_W + 1
) (
  input  logic [1:0]           rate_i,
  input  logic [PER_FLD_W-1:0] per_hi_i,
  input  logic [PER_FLD_W-1:0] per_lo_i,
  output logic [PER_W-1:0]     per_o
);

  // one extra ns bit so the fixed 16 ns period fits
  localparam logic [PER_W-1:0] PER_1G  = PER_W'(fix_period(160, FNS_W));
  localparam logic [PER_W-1:0] PER_2G5 = PER_W'(fix_period(64, FNS_W));

  always_comb begin
    unique case (rate_e'(rate_i))
      RATE_HIGH: per_o = {1'b0, per_hi_i};
      RATE_LOW:  per_o = {1'b0, per_lo_i};
      RATE_1G:   per_o = PER_1G;
      RATE_2G5:  per_o = PER_2G5;
      default:   per_o = {1'b0, per_hi_i};
    endcase
  end

endmodule

// File: rtl/ts_lat_path.sv
module ts_lat_path #(
  parameter int unsigned TS_NS_W  = 48,
  parameter int unsigned FNS_W    = 16,
  parameter int unsigned PER_W    = 21,
  parameter int unsigned STG_W    = 4,
  parameter int unsigned ADJ_NS_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic [TS_NS_W-1:0]  ts_ns_i,
  input  logic [FNS_W-1:0]    ts_fns_i,
  input  logic [STG_W-1:0]    stg_i,
  input  logic [PER_W-1:0]    per_i,
  input  logic [ADJ_NS_W-1:0] adj_ns_i,
  input  logic [FNS_W-1:0]    adj_fns_i,
  output logic                vld_o,
  output logic [TS_NS_W-1:0]  ts_ns_o,
  output logic [FNS_W-1:0]    ts_fns_o
);

  localparam int unsigned TS_W   = TS_NS_W + FNS_W;
  localparam int unsigned PROD_W = PER_W + STG_W;
  localparam int unsigned ADJ_W  = ADJ_NS_W + FNS_W;
  localparam int unsigned CORR_W = ((PROD_W > ADJ_W) ? PROD_W : ADJ_W) + 1;

  logic [PROD_W-1:0] prod;
  logic [CORR_W-1:0] corr;
  logic [TS_W-1:0]   sum;

  assign prod = PROD_W'(per_i) * PROD_W'(stg_i);
  assign corr = CORR_W'(prod) + CORR_W'({adj_ns_i, adj_fns_i});
  assign sum  = {ts_ns_i, ts_fns_i} + TS_W'(corr);

  logic            vld_q;
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ts_q  <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) ts_q <= sum;
    end
  end

  assign vld_o    = vld_q;
  assign ts_ns_o  = ts_q[TS_W-1:FNS_W];
  assign ts_fns_o = ts_q[FNS_W-1:0];

  p_vld_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> (!vld_o && $stable(ts_ns_o) && $stable(ts_fns_o)));

endmodule

// File: rtl/ts_lat_comp.sv
module ts_lat_comp
  import ts_lat_pkg::*;
#(
  parameter int unsigned TS_NS_W  = 48,
  parameter int unsigned FNS_W    = 16,
  parameter int unsigned PER_NS_W = 4,
  parameter int unsigned ADJ_NS_W = 16,
  parameter int unsigned STG_W    = 4,
  parameter int unsigned CFG_DW   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [1:0]         rate_i,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_addr_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  input  logic               tx_vld_i,
  input  logic [TS_NS_W-1:0] tx_ns_i,
  input  logic [FNS_W-1:0]   tx_fns_i,
  input  logic [STG_W-1:0]   tx_stg_i,
  input  logic               rx_vld_i,
  input  logic [TS_NS_W-1:0] rx_ns_i,
  input  logic [FNS_W-1:0]   rx_fns_i,
  input  logic [STG_W-1:0]   rx_stg_i,
  output logic               tx_vld_o,
  output logic [TS_NS_W-1:0] tx_ns_o,
  output logic [FNS_W-1:0]   tx_fns_o,
  output logic               rx_vld_o,
  output logic [TS_NS_W-1:0] rx_ns_o,
  output logic [FNS_W-1:0]   rx_fns_o
);

  localparam int unsigned PER_FLD_W = PER_NS_W + FNS_W;
  localparam int unsigned PER_W     = PER_FLD_W + 1;
  localparam logic [PER_W-1:0] PER_1G  = PER_W'(fix_period(160, FNS_W));
  localparam logic [PER_W-1:0] PER_2G5 = PER_W'(fix_period(64, FNS_W));

  logic                 vld_in  [DIR_N];
  logic [TS_NS_W-1:0]   ns_in   [DIR_N];
  logic [FNS_W-1:0]     fns_in  [DIR_N];
  logic [STG_W-1:0]     stg_in  [DIR_N];
  logic                 vld_out [DIR_N];
  logic [TS_NS_W-1:0]   ns_out  [DIR_N];
  logic [FNS_W-1:0]     fns_out [DIR_N];

  assign vld_in[0] = tx_vld_i;
  assign ns_in[0]  = tx_ns_i;
  assign fns_in[0] = tx_fns_i;
  assign stg_in[0] = tx_stg_i;
  assign vld_in[1] = rx_vld_i;
  assign ns_in[1]  = rx_ns_i;
  assign fns_in[1] = rx_fns_i;
  assign stg_in[1] = rx_stg_i;

  assign tx_vld_o = vld_out[0];
  assign tx_ns_o  = ns_out[0];
  assign tx_fns_o = fns_out[0];
  assign rx_vld_o = vld_out[1];
  assign rx_ns_o  = ns_out[1];
  assign rx_fns_o = fns_out[1];

  for (genvar d = 0; d < DIR_N; d++) begin : g_dir
    logic [PER_FLD_W-1:0] per_hi, per_lo;
    logic [ADJ_NS_W-1:0]  adj_ns;
    logic [FNS_W-1:0]     adj_fns;
    logic [PER_W-1:0]     per;

    ts_lat_cfg #(
      .DIR_ID  (d),
      .FNS_W   (FNS_W),
      .PER_NS_W(PER_NS_W),
      .ADJ_NS_W(ADJ_NS_W),
      .CFG_DW  (CFG_DW)
    ) cfg_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .we_i     (cfg_we_i),
      .addr_i   (cfg_addr_i),
      .wdata_i  (cfg_wdata_i),
      .per_hi_o (per_hi),
      .per_lo_o (per_lo),
      .adj_ns_o (adj_ns),
      .adj_fns_o(adj_fns)
    );

    ts_lat_per_sel #(
      .FNS_W   (FNS_W),
      .PER_NS_W(PER_NS_W)
    ) sel_i (
      .rate_i  (rate_i),
      .per_hi_i(per_hi),
      .per_lo_i(per_lo),
      .per_o   (per)
    );

    ts_lat_path #(
      .TS_NS_W (TS_NS_W),
      .FNS_W   (FNS_W),
      .PER_W   (PER_W),
      .STG_W   (STG_W),
      .ADJ_NS_W(ADJ_NS_W)
    ) path_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vld_i    (vld_in[d]),
      .ts_ns_i  (ns_in[d]),
      .ts_fns_i (fns_in[d]),
      .stg_i    (stg_in[d]),
      .per_i    (per),
      .adj_ns_i (adj_ns),
      .adj_fns_i(adj_fns),
      .vld_o    (vld_out[d]),
      .ts_ns_o  (ns_out[d]),
      .ts_fns_o (fns_out[d])
    );

    p_hi_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rate_i == RATE_HIGH) |-> (per == {1'b0, per_hi}));

    p_lo_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rate_i == RATE_LOW) |-> (per == {1'b0, per_lo}));

    p_force_1g_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rate_i == RATE_1G) |-> (per == PER_1G));

    p_force_2g5_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rate_i == RATE_2G5) |-> (per == PER_2G5));
  end

endmodule

// File: tb/ts_lat_comp_tb_top.sv
module ts_lat_comp_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  rate = 2'd0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic        tx_vld = 1'b0, rx_vld = 1'b0;
  logic [47:0] tx_ns = '0, rx_ns = '0;
  logic [15:0] tx_fns = '0, rx_fns = '0;
  logic [3:0]  tx_stg = '0, rx_stg = '0;
  logic        tx_vld_o, rx_vld_o;
  logic [47:0] tx_ns_o, rx_ns_o;
  logic [15:0] tx_fns_o, rx_fns_o;

  always #10 clk = ~clk;

  ts_lat_comp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rate_i(rate),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .tx_vld_i(tx_vld), .tx_ns_i(tx_ns), .tx_fns_i(tx_fns), .tx_stg_i(tx_stg),
    .rx_vld_i(rx_vld), .rx_ns_i(rx_ns), .rx_fns_i(rx_fns), .rx_stg_i(rx_stg),
    .tx_vld_o(tx_vld_o), .tx_ns_o(tx_ns_o), .tx_fns_o(tx_fns_o),
    .rx_vld_o(rx_vld_o), .rx_ns_o(rx_ns_o), .rx_fns_o(rx_fns_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the settings: [0] TX, [1] RX
  logic [19:0] m_hi [2];
  logic [19:0] m_lo [2];
  logic [15:0] m_ans [2];
  logic [15:0] m_afns [2];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] m_per(input int d, input int r);
    case (r)
      0: return 64'(m_hi[d]);
      1: return 64'(m_lo[d]);
      2: return 64'd16 << 16;
      default: return (64'd64 << 16) / 10;
    endcase
  endfunction

  function automatic logic [63:0] m_exp(input int d, input int r, input int stg, input logic [63:0] raw);
    return raw + m_per(d, r) * 64'(stg) + {32'd0, m_ans[d], m_afns[d]};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] dat);
    we = 1'b1; addr = a; wdata = dat;
    @(negedge clk);
    we = 1'b0;
    if (!en) begin
      case (a[1:0])
        2'd0: m_hi[a[2]]   = dat[19:0];
        2'd1: m_lo[a[2]]   = dat[19:0];
        2'd2: m_ans[a[2]]  = dat[15:0];
        default: m_afns[a[2]] = dat[15:0];
      endcase
    end
  endtask

  // drive both directions for one cycle, check one clock later
  task automatic run(input int r, input int st, input int sr,
                     input logic [63:0] rt, input logic [63:0] rr, input string req);
    logic [63:0] et, er;
    et = m_exp(0, r, st, rt);
    er = m_exp(1, r, sr, rr);
    rate = 2'(r);
    tx_vld = 1'b1; {tx_ns, tx_fns} = rt; tx_stg = 4'(st);
    rx_vld = 1'b1; {rx_ns, rx_fns} = rr; rx_stg = 4'(sr);
    @(negedge clk);
    tx_vld = 1'b0; rx_vld = 1'b0;
    chk(tx_vld_o && rx_vld_o, {req, " R3 valid"}, {62'd0, tx_vld_o, rx_vld_o}, 64'd3);
    chk({tx_ns_o, tx_fns_o} == et, {req, " tx"}, {tx_ns_o, tx_fns_o}, et);
    chk({rx_ns_o, rx_fns_o} == er, {req, " rx"}, {rx_ns_o, rx_fns_o}, er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] last_tx;
    for (int d = 0; d < 2; d++) begin
      m_hi[d] = 20'h33333; m_lo[d] = 20'h80000; m_ans[d] = '0; m_afns[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of outputs
    chk(!tx_vld_o && !rx_vld_o, "R1 valid after reset", {62'd0, tx_vld_o, rx_vld_o}, 64'd0);
    chk({tx_ns_o, tx_fns_o} == 64'd0, "R1 tx ts after reset", {tx_ns_o, tx_fns_o}, 64'd0);
    chk({rx_ns_o, rx_fns_o} == 64'd0, "R1 rx ts after reset", {rx_ns_o, rx_fns_o}, 64'd0);

    // R1 defaults under every mode and stage count
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 16; s++)
        run(r, s, 15 - s, 64'h0000_0102_0304_0000 + 64'(s) * 64'h1_0001,
            64'h0000_0A0B_0C0D_8000 + 64'(r), "R1 R2 defaults");

    // R9 writes while enabled are dropped
    en = 1'b1;
    wr(3'b000, 32'h0001_1111);
    wr(3'b110, 32'h0000_0077);
    run(0, 3, 3, 64'h0000_0000_1000_0000, 64'h0000_0000_2000_0000, "R9 locked");

    // R8 R10 load distinct settings, reserved bits set
    en = 1'b0;
    wr(3'b000, 32'hFFF2_4681);
    wr(3'b001, 32'hABC7_0F0F);
    wr(3'b010, 32'h1234_0005);
    wr(3'b011, 32'hFFFF_FFFF);
    wr(3'b100, 32'h0005_5555);
    wr(3'b101, 32'h0003_8000);
    wr(3'b110, 32'hFFFF_0100);
    wr(3'b111, 32'h0000_8001);
    en = 1'b1;
    run(0, 1, 1, 64'd0, 64'd0, "R8 R9 reserved bits and enable-low write");

    // R10 single-direction write leaves the other alone
    en = 1'b0;
    wr(3'b010, 32'h0000_0009);
    en = 1'b1;
    run(1, 7, 7, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0100, "R10 isolation");

    // R2 R4 R5 R6 R7 full sweep with fractional carry
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 16; s++)
        run(r, s, s, 64'h0000_1234_5678_FFF0 ^ (64'(s) << 20),
            64'h0000_0FED_CBA9_FF00 + 64'(s * 3), (r == 0) ? "R4 R2" :
            (r == 1) ? "R5 R2" : (r == 2) ? "R6 R2" : "R7 R2");

    // R11 wrap
    run(2, 15, 15, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFF0_0000, "R11 wrap");
    run(3, 15, 1, 64'hFFFF_FFFF_FFFF_0001, 64'hFFFF_FFFF_FFFF_FFFF, "R11 wrap");

    // R3 idle hold
    last_tx = m_exp(0, 0, 4, 64'h0000_0000_5555_0000);
    run(0, 4, 4, 64'h0000_0000_5555_0000, 64'h0000_0000_6666_0000, "R3 setup");
    tx_ns = 48'hAAAA; tx_fns = 16'h1; tx_stg = 4'd9; rate = 2'd2;
    @(negedge clk);
    chk(!tx_vld_o && !rx_vld_o, "R3 no valid", {62'd0, tx_vld_o, rx_vld_o}, 64'd0);
    chk({tx_ns_o, tx_fns_o} == last_tx, "R3 hold", {tx_ns_o, tx_fns_o}, last_tx);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule